// File: doc/BRIEF.md
# Interrupt Vector Translator and Delivery Holder

This block sits between interrupt-generating devices and a CPU core. A device presents a request value. The block turns that value into a CPU interrupt vector in one of two ways. With mapping enabled, it searches a small table of value/vector pairs that software writes. With mapping disabled, the value itself becomes the vector. The result is held in a single pending register. The block offers that vector to the CPU on every cycle until the CPU acknowledges it.

A request can arrive while an earlier vector is still waiting. If the new vector is the same as the pending one, the request is dropped. If it is different, a collision mode decides what happens: flag an error, let the newer vector win, or install one configured substitute vector. A value that matches no table entry also flags an error. The error flag is sticky and freezes the block until reset.

Top module: `irq_vec_xlate`

## Requirements
- R1: A request with `req_valid_i` low, or with `req_value_i` equal to zero, changes neither the pending vector nor `err_o`.
- R2: With `map_enable_i` high, a nonzero request value equal to a stored entry's value makes that entry's vector pending. When several entries match, the lowest index wins.
- R3: With `map_enable_i` high, a nonzero request value that matches no usable entry sets `err_o` on the next cycle.
- R4: With `map_enable_i` low, a nonzero request value becomes the pending vector unchanged (zero-extended to the vector width).
- R5: A request whose vector equals the currently pending vector is dropped: the vector is unchanged and no error is raised.
- R6: In collision modes 0 and 3 of `collide_mode_i`, a different vector arriving while one is pending sets `err_o`, and the pending vector keeps its old value.
- R7: In collision mode 1, a different vector arriving while one is pending replaces the pending vector.
- R8: In collision mode 2, a different vector arriving while one is pending is replaced by `collide_vec_i`, which then becomes pending.
- R9: `cpu_irq_o` is high exactly when `cpu_vec_o` is nonzero. The vector appears one cycle after the request and stays stable until `cpu_ack_i`. An acknowledge clears it to zero on the next cycle.
- R10: A table entry with a zero value field or a zero vector field never matches a request.
- R11: Once set, `err_o` stays high until reset. While it is high, requests and acknowledges are ignored and the pending vector is frozen.
- R12: A request and an acknowledge in the same cycle retire the old vector first. The new vector then becomes pending with no collision handling.
- R13: Reset clears the pending vector, `err_o` and every table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Device request strobe |
| req_value_i | input | VAL_W | Device request value (zero means no request) |
| map_enable_i | input | 1 | 1: translate through the table; 0: pass the value through |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | IDX_W | Table entry index to write |
| tbl_value_i | input | VAL_W | Value field written to the entry |
| tbl_vec_i | input | VEC_W | Vector field written to the entry |
| collide_mode_i | input | 2 | Collision mode: 0/3 error, 1 newest wins, 2 substitute vector |
| collide_vec_i | input | VEC_W | Substitute vector used by collision mode 2 |
| cpu_ack_i | input | 1 | CPU acknowledges the offered vector |
| cpu_irq_o | output | 1 | Interrupt offered to the CPU |
| cpu_vec_o | output | VEC_W | Pending vector (zero when idle) |
| err_o | output | 1 | Sticky error flag |

## Verification
The bench targets the ordering corners. It checks an acknowledge landing in the same cycle as a new request: a design that tests for a collision before retiring the old vector would raise a false error. It repeats the pending vector to catch a design that treats equal vectors as a collision. It loads duplicate table entries and entries with zero fields: wrong priority would pick the later entry, and a missing zero guard would match them. After an error, it sends both requests and acknowledges to confirm the block is frozen. It also resets a loaded table to catch a design that keeps old entries through reset.

// File: rtl/irq_xlate_pkg.sv
package irq_xlate_pkg;

   typedef enum logic [1:0] {
      COLL_ERROR     = 2'd0,
      COLL_NEWEST    = 2'd1,
      COLL_FIXED     = 2'd2,
      COLL_ERROR_ALT = 2'd3
   } coll_mode_e;

endpackage

// File: rtl/irq_xlate_table.sv
module irq_xlate_table #(
   parameter int ENTRIES = 8,
   parameter int VAL_W   = 32,
   parameter int VEC_W   = 32,
   parameter int IDX_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [VAL_W-1:0] wval_i,
   input  logic [VEC_W-1:0] wvec_i,
   input  logic [VAL_W-1:0] probe_i,
   output logic             hit_o,
   output logic [VEC_W-1:0] vec_o
);

   if (ENTRIES < 1) begin : g_chk_entries
      $error("irq_xlate_table: ENTRIES must be at least 1");
   end
   if ((1 << IDX_W) < ENTRIES) begin : g_chk_idx
      $error("irq_xlate_table: IDX_W too narrow for ENTRIES");
   end

   logic [ENTRIES-1:0] match;
   logic [VEC_W-1:0]   ent_vec [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic [VAL_W-1:0] val_q;
      logic [VEC_W-1:0] vec_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
            vec_q <= '0;
         end else if (we_i && (idx_i == IDX_W'(g))) begin
            val_q <= wval_i;
            vec_q <= wvec_i;
         end
      end

      // entries with a zero field are unused and never match
      assign match[g]   = (val_q != '0) && (vec_q != '0) && (val_q == probe_i);
      assign ent_vec[g] = vec_q;
   end

   // lowest index has priority
   always_comb begin
      hit_o = 1'b0;
      vec_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit_o = 1'b1;
            vec_o = ent_vec[i];
         end
      end
   end

   p_hit_nonzero_vec_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (vec_o != '0));
   p_hit_nonzero_probe_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (probe_i != '0));

endmodule

// File: rtl/irq_pending_ctrl.sv
module irq_pending_ctrl
   import irq_xlate_pkg::*;
#(
   parameter int VEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic             ok_i,
   input  logic [VEC_W-1:0] cand_i,
   input  logic [1:0]       mode_i,
   input  logic [VEC_W-1:0] subst_i,
   input  logic             ack_i,
   output logic [VEC_W-1:0] pend_o,
   output logic             err_o
);

   logic [VEC_W-1:0] pend_q, pend_d, base;
   logic             err_q, err_d;
   coll_mode_e       mode;

   assign mode = coll_mode_e'(mode_i);

   always_comb begin
      // an acknowledge retires the current vector before new arrivals are judged
      base   = (ack_i && (pend_q != '0)) ? '0 : pend_q;
      pend_d = base;
      err_d  = err_q;
      if (err_q) begin
         pend_d = pend_q;
      end else if (fire_i) begin
         if (!ok_i) begin
            err_d = 1'b1;
         end else if (base == '0) begin
            pend_d = cand_i;
         end else if (cand_i != base) begin
            unique case (mode)
               COLL_NEWEST: pend_d = cand_i;
               COLL_FIXED:  pend_d = subst_i;
               default:     err_d  = 1'b1;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         err_q  <= 1'b0;
      end else begin
         pend_q <= pend_d;
         err_q  <= err_d;
      end
   end

   assign pend_o = pend_q;
   assign err_o  = err_q;

   p_err_sticky_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
   p_err_freeze_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> $stable(pend_q));
   p_hold_until_ack_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q && pend_q != '0 && !ack_i && !fire_i) |=> $stable(pend_q));
   p_ack_clears_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q && pend_q != '0 && ack_i && !fire_i) |=> (pend_q == '0));
   p_miss_errs_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q && fire_i && !ok_i) |=> err_q);
   p_same_drop_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q && fire_i && ok_i && !ack_i && pend_q != '0 && cand_i == pend_q)
      |=> ($stable(pend_q) && !err_q));
   p_newest_wins_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q && fire_i && ok_i && !ack_i && pend_q != '0 && cand_i != pend_q
       && mode_i == 2'd1) |=> (pend_q == $past(cand_i)));
   p_ack_then_new_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q && fire_i && ok_i && ack_i && pend_q != '0)
      |=> (pend_q == $past(cand_i) && !err_q));

endmodule

// File: rtl/irq_vec_xlate.sv
module irq_vec_xlate #(
   parameter int ENTRIES = 8,
   parameter int VAL_W   = 32,
   parameter int VEC_W   = 32,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid_i,
   input  logic [VAL_W-1:0] req_value_i,
   input  logic             map_enable_i,
   input  logic             tbl_we_i,
   input  logic [IDX_W-1:0] tbl_idx_i,
   input  logic [VAL_W-1:0] tbl_value_i,
   input  logic [VEC_W-1:0] tbl_vec_i,
   input  logic [1:0]       collide_mode_i,
   input  logic [VEC_W-1:0] collide_vec_i,
   input  logic             cpu_ack_i,
   output logic             cpu_irq_o,
   output logic [VEC_W-1:0] cpu_vec_o,
   output logic             err_o
);

   if (VEC_W < VAL_W) begin : g_chk_width
      $error("irq_vec_xlate: VEC_W must not be narrower than VAL_W");
   end

   logic             fire;
   logic             tbl_hit;
   logic [VEC_W-1:0] tbl_vec;
   logic [VEC_W-1:0] pass_vec;
   logic [VEC_W-1:0] cand;
   logic             cand_ok;

   assign fire = req_valid_i && (req_value_i != '0);

   if (VEC_W == VAL_W) begin : g_pass_same
      assign pass_vec = req_value_i;
   end else begin : g_pass_ext
      assign pass_vec = {{(VEC_W - VAL_W){1'b0}}, req_value_i};
   end

   irq_xlate_table #(
      .ENTRIES (ENTRIES),
      .VAL_W   (VAL_W),
      .VEC_W   (VEC_W),
      .IDX_W   (IDX_W)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (tbl_we_i),
      .idx_i   (tbl_idx_i),
      .wval_i  (tbl_value_i),
      .wvec_i  (tbl_vec_i),
      .probe_i (req_value_i),
      .hit_o   (tbl_hit),
      .vec_o   (tbl_vec)
   );

   assign cand    = map_enable_i ? tbl_vec : pass_vec;
   assign cand_ok = map_enable_i ? tbl_hit : 1'b1;

   irq_pending_ctrl #(
      .VEC_W (VEC_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (fire),
      .ok_i    (cand_ok),
      .cand_i  (cand),
      .mode_i  (collide_mode_i),
      .subst_i (collide_vec_i),
      .ack_i   (cpu_ack_i),
      .pend_o  (cpu_vec_o),
      .err_o   (err_o)
   );

   assign cpu_irq_o = (cpu_vec_o != '0);

   p_zero_ignored_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (!err_o && !(req_valid_i && req_value_i != '0) && !cpu_ack_i)
      |=> ($stable(cpu_vec_o) && !err_o));
   p_passthrough_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!err_o && !map_enable_i && req_valid_i && req_value_i != '0 && !cpu_irq_o)
      |=> (cpu_vec_o == VEC_W'($past(req_value_i))));

endmodule

// File: tb/irq_vec_xlate_tb.sv
`timescale 1ns/1ps
module irq_vec_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_value = '0;
   logic        map_en = 1'b0;
   logic        tbl_we = 1'b0;
   logic [2:0]  tbl_idx = '0;
   logic [31:0] tbl_value = '0;
   logic [31:0] tbl_vec = '0;
   logic [1:0]  cmode = 2'd0;
   logic [31:0] cvec = '0;
   logic        ack = 1'b0;
   logic        irq;
   logic [31:0] vec;
   logic        err;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   irq_vec_xlate u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid_i    (req_valid),
      .req_value_i    (req_value),
      .map_enable_i   (map_en),
      .tbl_we_i       (tbl_we),
      .tbl_idx_i      (tbl_idx),
      .tbl_value_i    (tbl_value),
      .tbl_vec_i      (tbl_vec),
      .collide_mode_i (cmode),
      .collide_vec_i  (cvec),
      .cpu_ack_i      (ack),
      .cpu_irq_o      (irq),
      .cpu_vec_o      (vec),
      .err_o          (err)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req_valid = 1'b0; req_value = '0; ack = 1'b0; tbl_we = 1'b0;
      map_en = 1'b0; cmode = 2'd0; cvec = '0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic wr_entry(input int idx, input logic [31:0] v, input logic [31:0] x);
      tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_value = v; tbl_vec = x;
      step();
      tbl_we = 1'b0;
   endtask

   task automatic request(input logic vld, input logic [31:0] v, input logic a);
      req_valid = vld; req_value = v; ack = a;
      step();
      req_valid = 1'b0; req_value = '0; ack = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R13", "irq after reset", 32'(irq), 32'd0);
      chk("R13", "vec after reset", vec, 32'd0);
      chk("R13", "err after reset", 32'(err), 32'd0);
      wr_entry(0, 32'h10, 32'h40);
      do_reset();
      map_en = 1'b1;
      request(1'b1, 32'h10, 1'b0);
      chk("R13", "table cleared by reset", 32'(err), 32'd1);
   endtask

   task automatic t_passthrough();
      do_reset();
      request(1'b1, 32'h1234, 1'b0);
      chk("R4", "passthrough vec", vec, 32'h1234);
      chk("R9", "irq high", 32'(irq), 32'd1);
      step(); step(); step();
      chk("R9", "held without ack", vec, 32'h1234);
      request(1'b0, 32'h0, 1'b1);
      chk("R9", "ack clears vec", vec, 32'd0);
      chk("R9", "ack clears irq", 32'(irq), 32'd0);
   endtask

   task automatic t_zero();
      do_reset();
      request(1'b1, 32'h0, 1'b0);
      chk("R1", "zero value ignored", vec, 32'd0);
      request(1'b0, 32'h77, 1'b0);
      chk("R1", "no valid ignored", vec, 32'd0);
      request(1'b1, 32'h5, 1'b0);
      request(1'b1, 32'h0, 1'b0);
      chk("R1", "zero keeps pending", vec, 32'h5);
      chk("R1", "zero no error", 32'(err), 32'd0);
   endtask

   task automatic t_map();
      do_reset();
      wr_entry(0, 32'h10, 32'h40);
      wr_entry(1, 32'h20, 32'h41);
      wr_entry(2, 32'h10, 32'h99);
      map_en = 1'b1;
      request(1'b1, 32'h10, 1'b0);
      chk("R2", "lowest index wins", vec, 32'h40);
      request(1'b0, 32'h0, 1'b1);
      request(1'b1, 32'h20, 1'b0);
      chk("R2", "second entry", vec, 32'h41);
      chk("R2", "no error", 32'(err), 32'd0);
   endtask

   task automatic t_zero_entries();
      do_reset();
      wr_entry(3, 32'h30, 32'h0);
      wr_entry(4, 32'h0, 32'h77);
      map_en = 1'b1;
      request(1'b1, 32'h30, 1'b0);
      chk("R10", "zero-vector entry unused", 32'(err), 32'd1);
      chk("R10", "nothing pending", vec, 32'd0);
   endtask

   task automatic t_unmapped();
      do_reset();
      wr_entry(0, 32'h10, 32'h40);
      map_en = 1'b1;
      request(1'b1, 32'h55, 1'b0);
      chk("R3", "unmapped sets err", 32'(err), 32'd1);
      request(1'b1, 32'h10, 1'b0);
      chk("R11", "request ignored in error", vec, 32'd0);
      step(); step();
      chk("R11", "err sticky", 32'(err), 32'd1);
   endtask

   task automatic t_same();
      do_reset();
      request(1'b1, 32'h7, 1'b0);
      request(1'b1, 32'h7, 1'b0);
      chk("R5", "same vector kept", vec, 32'h7);
      chk("R5", "same vector no err", 32'(err), 32'd0);
   endtask

   task automatic t_abort(input logic [1:0] m);
      do_reset();
      cmode = m;
      request(1'b1, 32'h7, 1'b0);
      request(1'b1, 32'h9, 1'b0);
      chk("R6", "collision err", 32'(err), 32'd1);
      chk("R6", "pending unchanged", vec, 32'h7);
      request(1'b0, 32'h0, 1'b1);
      chk("R11", "ack ignored in error", vec, 32'h7);
   endtask

   task automatic t_replace();
      do_reset();
      cmode = 2'd1;
      request(1'b1, 32'h7, 1'b0);
      request(1'b1, 32'h9, 1'b0);
      chk("R7", "newest wins", vec, 32'h9);
      chk("R7", "no err", 32'(err), 32'd0);
   endtask

   task automatic t_fixed();
      do_reset();
      cmode = 2'd2; cvec = 32'hEE;
      request(1'b1, 32'h7, 1'b0);
      request(1'b1, 32'h9, 1'b0);
      chk("R8", "substitute vector", vec, 32'hEE);
      chk("R8", "no err", 32'(err), 32'd0);
   endtask

   task automatic t_ack_req();
      do_reset();
      cmode = 2'd0;
      request(1'b1, 32'h7, 1'b0);
      request(1'b1, 32'h9, 1'b1);
      chk("R12", "new vector after ack", vec, 32'h9);
      chk("R12", "no collision err", 32'(err), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_passthrough();
      t_zero();
      t_map();
      t_zero_entries();
      t_unmapped();
      t_same();
      t_abort(2'd0);
      t_abort(2'd3);
      t_replace();
      t_fixed();
      t_ack_req();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule